// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a small in-order integer core that runs a subset of 32-bit register-register and load/store instructions. An instruction goes through fetch, decode with register read, execute or address calculation, data memory access, and register write-back. A pipeline register sits between each pair of stages. Each clock edge moves every instruction one stage forward, and a new word is fetched in the same cycle. The core has its own word-wide instruction memory and data memory, held as internal arrays, and a 32-entry register file.

Decode produces all the control bits. The control for execute, for memory access and for write-back travels with the instruction in separate groups, so each stage is steered only by the bits of the instruction that is in it. The destination register number also travels with the instruction to write-back. Write-back therefore uses the carried copy and never the word that is in decode at that time.

There is no branch logic, no hazard detection and no forwarding. Software, here the testbench, keeps any consumer at least three instructions behind its producer. The testbench loads the instruction memory before it releases reset. It observes results through a combinational debug read port into the register file.

Top module: `pipe5_core`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), the program counter is 0 and every pipeline stage holds a bubble with its register-write and memory-write enables at 0. An instruction in flight when reset asserts never writes the register file.
- R2: Opcode 0 with function code 0x20 adds, 0x22 subtracts (rs minus rt), 0x24 ANDs and 0x25 ORs. The source fields are bits 25:21 (rs) and 20:16 (rt), the destination is bits 15:11 (rd), and the result is taken modulo 2^32.
- R3: Opcode 0x23 loads into rt the data word at index ((rs + offset) >> 2) modulo DMEM_WORDS. The offset is bits 15:0, and address bits 1:0 are ignored.
- R4: Opcode 0x2B stores rt into that same data word. It writes no register, including the register named by bits 15:11.
- R5: The 16-bit offset is sign-extended. For example, offset -8 from register 0 addresses word DMEM_WORDS-2.
- R6: Register 0 reads as zero on every read port, including the debug port, and writes to it are discarded.
- R7: A value written back in a cycle is seen by the instruction in decode in that same cycle. An instruction three slots after its producer therefore reads the new value.
- R8: The result of the instruction at word k shows on the debug port after the (k+4)th rising edge following reset release, and not after the (k+3)th. It lands in the register that instruction named.
- R9: Any other opcode, or opcode 0 with any other function code, changes no register and no memory word.
- R10: At power-up, data word i holds DMEM_SEED XOR (i * DMEM_STEP) modulo 2^32. The defaults are 0x12345678 and 0x9E3779B9. A load right after a store to the same word returns the stored value.
- R11: The program counter starts at 0 and advances by 4 every cycle. Instructions take effect in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the program counter and pipeline registers |
| dbg_addr | input | 5 | Register number read by the debug port |
| dbg_data | output | 32 | Combinational value of register `dbg_addr`, including a write landing this cycle |

## Verification
The main program loads seed words with zero, positive and negative offsets, then mixes all four ALU operations on those values. The final register image is compared with a sequential reference model, which tells apart wrong operations, wrong operand fields and wrong destinations. Several operands sit exactly three slots behind their producer. Encodings that must do nothing are placed so that a wrong write would change a known register: a store whose offset bits name a register, an unknown opcode and an unknown function code. A store followed at once by a load of the same word separates the memory write timing from the read timing. A second program with a single instruction at word 3 is run twice. One run is cut by reset while that instruction is in flight, which shows the squash. The other is sampled one edge before and one edge after the expected write-back, which pins the latency.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned REG_AW = 5;

   // instruction encodings decoded by the core
   localparam logic [5:0] OPC_ALU   = 6'h00;
   localparam logic [5:0] OPC_LOAD  = 6'h23;
   localparam logic [5:0] OPC_STORE = 6'h2B;
   localparam logic [5:0] FN_ADD    = 6'h20;
   localparam logic [5:0] FN_SUB    = 6'h22;
   localparam logic [5:0] FN_AND    = 6'h24;
   localparam logic [5:0] FN_OR     = 6'h25;

   typedef enum logic [1:0] {
      ALU_ADD = 2'd0,
      ALU_SUB = 2'd1,
      ALU_AND = 2'd2,
      ALU_OR  = 2'd3
   } alu_op_e;

   // control consumed in execute
   typedef struct packed {
      logic    use_imm;
      alu_op_e alu_op;
   } ex_ctrl_t;

   // control consumed in memory access
   typedef struct packed {
      logic mem_rd;
      logic mem_we;
   } mem_ctrl_t;

   typedef struct packed {
      logic      rf_we;
      mem_ctrl_t m;
      ex_ctrl_t  e;
   } ctrl_t;

   typedef struct packed {
      logic [WORD_W-1:0] instr;
   } ifid_t;

   typedef struct packed {
      ctrl_t             ctrl;
      logic [REG_AW-1:0] dest;
      logic [WORD_W-1:0] opa;
      logic [WORD_W-1:0] opb;
      logic [WORD_W-1:0] imm;
   } idex_t;

   typedef struct packed {
      logic              rf_we;
      mem_ctrl_t         m;
      logic [REG_AW-1:0] dest;
      logic [WORD_W-1:0] alu_y;
      logic [WORD_W-1:0] st_data;
   } exmem_t;

   typedef struct packed {
      logic              rf_we;
      logic [REG_AW-1:0] dest;
      logic [WORD_W-1:0] wdata;
   } memwb_t;

endpackage

// File: rtl/pipe5_wmem.sv
module pipe5_wmem #(
   parameter int unsigned WORDS     = 64,
   parameter bit          WRITABLE  = 1'b1,
   parameter logic [31:0] FILL_SEED = 32'h0,
   parameter logic [31:0] FILL_STEP = 32'h0
) (
   input  logic        clk,
   input  logic        we,
   input  logic [31:0] addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata
);

   localparam int unsigned AW = $clog2(WORDS);

   generate
      if (WORDS < 4 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
         $error("pipe5_wmem: WORDS must be a power of two of at least 4");
      end
      if (AW + 2 > 31) begin : g_bad_size
         $error("pipe5_wmem: WORDS too large for a 32-bit byte address");
      end
   endgenerate

   logic [31:0]   mem [WORDS];
   logic [AW-1:0] idx;

   assign idx   = addr[AW+1:2];
   assign rdata = mem[idx];

   initial begin
      for (int i = 0; i < int'(WORDS); i++) begin
         mem[i] = FILL_SEED ^ (32'(i) * FILL_STEP);
      end
   end

   generate
      if (WRITABLE) begin : g_rw
         logic unused_addr;
         assign unused_addr = ^{addr[1:0], addr[31:AW+2]};
         always_ff @(posedge clk) begin
            if (we) begin
               mem[idx] <= wdata;
            end
         end
      end else begin : g_ro
         logic unused_wport;
         assign unused_wport = ^{we, wdata, addr[1:0], addr[31:AW+2]};
      end
   endgenerate

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile
   import pipe5_pkg::*;
#(
   parameter int unsigned RD_PORTS = 3
) (
   input  logic              clk,
   input  logic              we,
   input  logic [REG_AW-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [REG_AW-1:0] raddr [RD_PORTS],
   output logic [WORD_W-1:0] rdata [RD_PORTS]
);

   localparam int unsigned NREGS = 1 << REG_AW;

   generate
      if (RD_PORTS < 1) begin : g_bad_ports
         $error("pipe5_regfile: at least one read port is needed");
      end
   endgenerate

   logic [WORD_W-1:0] regs [NREGS];
   logic              wr_live;

   assign wr_live = we && (waddr != '0);

   always_ff @(posedge clk) begin
      if (wr_live) begin
         regs[waddr] <= wdata;
      end
   end

   // write-through read ports: a landing write is visible in the same cycle
   generate
      for (genvar p = 0; p < int'(RD_PORTS); p++) begin : g_rd
         assign rdata[p] = (raddr[p] == '0)                ? '0    :
                           (wr_live && waddr == raddr[p])  ? wdata :
                                                             regs[raddr[p]];
      end
   endgenerate

endmodule

// File: rtl/pipe5_decode.sv
module pipe5_decode
   import pipe5_pkg::*;
(
   input  logic [WORD_W-1:0] instr,
   output ctrl_t             ctrl,
   output logic [REG_AW-1:0] rs,
   output logic [REG_AW-1:0] rt,
   output logic [REG_AW-1:0] dest,
   output logic [WORD_W-1:0] imm_ext
);

   logic [5:0]        opcode;
   logic [5:0]        funct;
   logic [REG_AW-1:0] rd;

   // source fields sit at fixed positions, readable before the opcode is known
   assign opcode  = instr[31:26];
   assign rs      = instr[25:21];
   assign rt      = instr[20:16];
   assign rd      = instr[15:11];
   assign funct   = instr[5:0];
   assign imm_ext = {{(WORD_W-16){instr[15]}}, instr[15:0]};

   logic unused_shamt;
   assign unused_shamt = ^instr[10:6];

   always_comb begin
      ctrl = '0;
      dest = '0;
      unique case (opcode)
         OPC_ALU: begin
            dest = rd;
            unique case (funct)
               FN_ADD: begin ctrl.rf_we = 1'b1; ctrl.e.alu_op = ALU_ADD; end
               FN_SUB: begin ctrl.rf_we = 1'b1; ctrl.e.alu_op = ALU_SUB; end
               FN_AND: begin ctrl.rf_we = 1'b1; ctrl.e.alu_op = ALU_AND; end
               FN_OR:  begin ctrl.rf_we = 1'b1; ctrl.e.alu_op = ALU_OR;  end
               default: dest = '0;
            endcase
         end
         OPC_LOAD: begin
            ctrl.rf_we     = 1'b1;
            ctrl.m.mem_rd  = 1'b1;
            ctrl.e.use_imm = 1'b1;
            ctrl.e.alu_op  = ALU_ADD;
            dest           = rt;
         end
         OPC_STORE: begin
            ctrl.m.mem_we  = 1'b1;
            ctrl.e.use_imm = 1'b1;
            ctrl.e.alu_op  = ALU_ADD;
         end
         default: ctrl = '0;
      endcase
   end

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
   import pipe5_pkg::*;
(
   input  alu_op_e           op,
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   output logic [WORD_W-1:0] y
);

   always_comb begin
      unique case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
   import pipe5_pkg::*;
#(
   parameter int unsigned IMEM_WORDS = 64,
   parameter int unsigned DMEM_WORDS = 64,
   parameter logic [31:0] DMEM_SEED  = 32'h1234_5678,
   parameter logic [31:0] DMEM_STEP  = 32'h9E37_79B9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] dbg_addr,
   output logic [WORD_W-1:0] dbg_data
);

   localparam int unsigned RF_PORTS = 3;
   localparam logic [31:0] PC_STEP  = 32'd4;

   // ---------------- fetch ----------------
   logic [31:0]       pc_q;
   logic [WORD_W-1:0] fetch_word;
   ifid_t             ifid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else begin
         pc_q <= pc_q + PC_STEP;
      end
   end

   pipe5_wmem #(
      .WORDS     (IMEM_WORDS),
      .WRITABLE  (1'b0),
      .FILL_SEED (32'h0),
      .FILL_STEP (32'h0)
   ) u_imem (
      .clk   (clk),
      .we    (1'b0),
      .addr  (pc_q),
      .wdata ('0),
      .rdata (fetch_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ifid_q <= '0;
      end else begin
         ifid_q.instr <= fetch_word;
      end
   end

   // ---------------- decode / register read ----------------
   ctrl_t             dec_ctrl;
   logic [REG_AW-1:0] dec_rs;
   logic [REG_AW-1:0] dec_rt;
   logic [REG_AW-1:0] dec_dest;
   logic [WORD_W-1:0] dec_imm;
   logic [WORD_W-1:0] rs_val;
   logic [WORD_W-1:0] rt_val;
   logic [REG_AW-1:0] rf_raddr [RF_PORTS];
   logic [WORD_W-1:0] rf_rdata [RF_PORTS];
   idex_t             idex_q;
   memwb_t            memwb_q;

   pipe5_decode u_decode (
      .instr   (ifid_q.instr),
      .ctrl    (dec_ctrl),
      .rs      (dec_rs),
      .rt      (dec_rt),
      .dest    (dec_dest),
      .imm_ext (dec_imm)
   );

   assign rf_raddr[0] = dec_rs;
   assign rf_raddr[1] = dec_rt;
   assign rf_raddr[2] = dbg_addr;
   assign rs_val      = rf_rdata[0];
   assign rt_val      = rf_rdata[1];
   assign dbg_data    = rf_rdata[2];

   pipe5_regfile #(
      .RD_PORTS (RF_PORTS)
   ) u_regfile (
      .clk   (clk),
      .we    (memwb_q.rf_we),
      .waddr (memwb_q.dest),
      .wdata (memwb_q.wdata),
      .raddr (rf_raddr),
      .rdata (rf_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idex_q <= '0;
      end else begin
         idex_q.ctrl <= dec_ctrl;
         idex_q.dest <= dec_dest;
         idex_q.opa  <= rs_val;
         idex_q.opb  <= rt_val;
         idex_q.imm  <= dec_imm;
      end
   end

   // ---------------- execute / address ----------------
   logic [WORD_W-1:0] alu_b;
   logic [WORD_W-1:0] alu_y;
   exmem_t            exmem_q;

   assign alu_b = idex_q.ctrl.e.use_imm ? idex_q.imm : idex_q.opb;

   pipe5_alu u_alu (
      .op (idex_q.ctrl.e.alu_op),
      .a  (idex_q.opa),
      .b  (alu_b),
      .y  (alu_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exmem_q <= '0;
      end else begin
         exmem_q.rf_we   <= idex_q.ctrl.rf_we;
         exmem_q.m       <= idex_q.ctrl.m;
         exmem_q.dest    <= idex_q.dest;
         exmem_q.alu_y   <= alu_y;
         exmem_q.st_data <= idex_q.opb;
      end
   end

   // ---------------- memory access ----------------
   logic [WORD_W-1:0] dmem_rdata;
   logic [WORD_W-1:0] mem_result;

   pipe5_wmem #(
      .WORDS     (DMEM_WORDS),
      .WRITABLE  (1'b1),
      .FILL_SEED (DMEM_SEED),
      .FILL_STEP (DMEM_STEP)
   ) u_dmem (
      .clk   (clk),
      .we    (exmem_q.m.mem_we),
      .addr  (exmem_q.alu_y),
      .wdata (exmem_q.st_data),
      .rdata (dmem_rdata)
   );

   assign mem_result = exmem_q.m.mem_rd ? dmem_rdata : exmem_q.alu_y;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         memwb_q <= '0;
      end else begin
         memwb_q.rf_we <= exmem_q.rf_we;
         memwb_q.dest  <= exmem_q.dest;
         memwb_q.wdata <= mem_result;
      end
   end

   // write-back happens in u_regfile from memwb_q

endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk
   import pipe5_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       pc_q,
   input idex_t             idex_q,
   input exmem_t            exmem_q,
   input memwb_t            memwb_q,
   input logic [REG_AW-1:0] dec_rs,
   input logic [WORD_W-1:0] rs_val,
   input logic [REG_AW-1:0] dbg_addr,
   input logic [WORD_W-1:0] dbg_data
);

   AST_RESET_BUBBLE: assert property (@(posedge clk)
      !rst_n |-> (pc_q == '0 && !idex_q.ctrl.rf_we && !idex_q.ctrl.m.mem_we &&
                  !exmem_q.rf_we && !exmem_q.m.mem_we && !memwb_q.rf_we)); // R1

   AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      exmem_q.m.mem_we |=> !memwb_q.rf_we); // R4

   AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_addr == '0) |-> (dbg_data == '0)); // R6

   AST_WB_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (memwb_q.rf_we && memwb_q.dest != '0 && dec_rs == memwb_q.dest)
         |-> (rs_val == memwb_q.wdata)); // R7

   AST_DEST_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (memwb_q.dest == $past(exmem_q.dest) &&
                 memwb_q.rf_we == $past(exmem_q.rf_we))); // R8

   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (pc_q == $past(pc_q) + 32'd4)); // R11

endmodule

bind pipe5_core pipe5_core_chk u_chk (.*);

// File: tb/pipe5_core_bench.sv
module pipe5_core_bench;

   localparam int          DMEM_N = 64;
   localparam int          IMEM_N = 64;
   localparam logic [31:0] SEED   = 32'h1234_5678;
   localparam logic [31:0] STEP   = 32'h9E37_79B9;
   localparam logic [5:0]  F_ADD  = 6'h20;
   localparam logic [5:0]  F_SUB  = 6'h22;
   localparam logic [5:0]  F_AND  = 6'h24;
   localparam logic [5:0]  F_OR   = 6'h25;
   localparam logic [5:0]  O_LD   = 6'h23;
   localparam logic [5:0]  O_ST   = 6'h2B;

   function automatic logic [31:0] f_r(logic [5:0] fn, logic [4:0] rd, logic [4:0] rs, logic [4:0] rt);
      return {6'h00, rs, rt, rd, 5'h00, fn};
   endfunction

   function automatic logic [31:0] f_i(logic [5:0] op, logic [4:0] rt, logic [4:0] rs, logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   localparam int PLEN = 24;
   localparam logic [31:0] PROG [PLEN] = '{
      f_i(O_LD, 5'd1, 5'd0, 16'h0000),   // 0
      f_i(O_LD, 5'd2, 5'd0, 16'h0004),   // 1
      f_i(O_LD, 5'd3, 5'd0, 16'h0008),   // 2
      f_i(O_LD, 5'd4, 5'd0, 16'h000C),   // 3
      f_i(O_LD, 5'd9, 5'd0, 16'hFFF8),   // 4  negative offset, R5
      f_r(F_ADD, 5'd5, 5'd1, 5'd2),      // 5
      f_r(F_SUB, 5'd6, 5'd3, 5'd4),      // 6  three slots after word 3, R7
      f_r(F_AND, 5'd7, 5'd1, 5'd3),      // 7
      f_r(F_OR,  5'd8, 5'd2, 5'd4),      // 8
      f_r(F_ADD, 5'd11, 5'd1, 5'd1),     // 9
      f_r(F_SUB, 5'd12, 5'd2, 5'd1),     // 10
      f_r(F_ADD, 5'd21, 5'd3, 5'd9),     // 11
      f_r(F_ADD, 5'd0, 5'd1, 5'd2),      // 12 write to r0, R6
      f_i(O_ST, 5'd5, 5'd0, 16'h5808),   // 13 bits 15:11 name r11, R4
      f_i(O_LD, 5'd10, 5'd0, 16'h0008),  // 14 load right after store, R10
      f_i(6'h08, 5'd12, 5'd1, 16'h0005), // 15 unknown opcode, R9
      f_r(6'h21, 5'd11, 5'd1, 5'd2),     // 16 unknown function, R9
      f_r(F_ADD, 5'd13, 5'd0, 5'd0),     // 17
      f_i(O_ST, 5'd6, 5'd0, 16'hFFFC),   // 18
      f_i(O_LD, 5'd14, 5'd0, 16'hFFFC),  // 19
      32'h0,                             // 20
      32'h0,                             // 21
      32'h0,                             // 22
      f_r(F_OR, 5'd15, 5'd10, 5'd14)     // 23
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  dbg_addr = '0;
   logic [31:0] dbg_data;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   logic [31:0] ref_rf  [32];
   bit          ref_ok  [32];
   string       ref_tag [32];
   logic [31:0] ref_dm  [DMEM_N];

   always #2 clk = ~clk;

   pipe5_core u_pipe5_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .dbg_addr (dbg_addr),
      .dbg_data (dbg_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic peek(input int r, output logic [31:0] v);
      dbg_addr = 5'(r);
      #1;
      v = dbg_data;
   endtask

   // sequential model of the instruction set, built from the requirements
   task automatic run_ref();
      for (int i = 0; i < DMEM_N; i++) ref_dm[i] = SEED ^ (32'(i) * STEP);
      for (int r = 0; r < 32; r++) begin
         ref_ok[r] = 1'b0;
         ref_rf[r] = '0;
         ref_tag[r] = "R2";
      end
      ref_ok[0] = 1'b1;
      ref_tag[0] = "R6";
      for (int k = 0; k < PLEN; k++) begin
         logic [31:0] w, a, b, ea, res;
         logic [4:0]  rs, rt, rd;
         w  = PROG[k];
         rs = w[25:21];
         rt = w[20:16];
         rd = w[15:11];
         a  = ref_rf[rs];
         b  = ref_rf[rt];
         ea = a + {{16{w[15]}}, w[15:0]};
         if (w[31:26] == 6'h00 && (w[5:0] == F_ADD || w[5:0] == F_SUB ||
                                   w[5:0] == F_AND || w[5:0] == F_OR)) begin
            case (w[5:0])
               F_ADD:   res = a + b;
               F_SUB:   res = a - b;
               F_AND:   res = a & b;
               default: res = a | b;
            endcase
            if (rd != 0) begin
               ref_rf[rd] = res; ref_ok[rd] = 1'b1; ref_tag[rd] = "R2";
            end
         end else if (w[31:26] == O_LD) begin
            if (rt != 0) begin
               ref_rf[rt] = ref_dm[ea[7:2]]; ref_ok[rt] = 1'b1;
               ref_tag[rt] = w[15] ? "R5" : "R3";
            end
         end else if (w[31:26] == O_ST) begin
            ref_dm[ea[7:2]] = b;
         end
      end
   endtask

   initial begin
      logic [31:0] v, old21, new21;
      #1;
      for (int i = 0; i < IMEM_N; i++) u_pipe5_core.u_imem.mem[i] = (i < PLEN) ? PROG[i] : 32'h0;
      run_ref();

      peek(0, v);
      check("R1 r0 during reset", v, 32'h0);

      // main program, table walked once, then the register image compared
      @(negedge clk) rst_n = 1'b1;
      repeat (PLEN + 10) @(posedge clk);
      @(negedge clk) rst_n = 1'b0;
      for (int r = 1; r < 32; r++) begin
         if (ref_ok[r]) begin
            peek(r, v);
            check(ref_tag[r], v, ref_rf[r]);
         end
      end

      // directed corner cases
      peek(0, v);  check("R6 r0 after write attempt", v, 32'h0);
      peek(13, v); check("R6 r0 read as operand", v, 32'h0);
      peek(11, v); check("R4 store offset bits leave r11", v, ref_rf[1] + ref_rf[1]);
      peek(12, v); check("R9 unknown encodings leave r12", v, ref_rf[2] - ref_rf[1]);
      peek(10, v); check("R10 load after store", v, ref_rf[5]);
      peek(3, v);  check("R10 power-up word 2", v, SEED ^ (32'd2 * STEP));
      peek(6, v);  check("R7 operand three slots behind", v, ref_rf[3] - ref_rf[4]);
      peek(9, v);  check("R5 negative offset word 62", v, SEED ^ (32'd62 * STEP));
      peek(14, v); check("R5 store and load at offset -4", v, ref_rf[6]);
      peek(15, v); check("R11 program order result", v, ref_rf[10] | ref_rf[14]);

      old21 = ref_rf[21];
      new21 = ref_rf[1] + ref_rf[2];

      // reset squashes an instruction in flight
      for (int i = 0; i < IMEM_N; i++) u_pipe5_core.u_imem.mem[i] = 32'h0;
      u_pipe5_core.u_imem.mem[3] = f_r(F_ADD, 5'd21, 5'd1, 5'd2);
      dbg_addr = 5'd21;
      @(negedge clk) rst_n = 1'b1;
      repeat (6) @(posedge clk);
      @(negedge clk) rst_n = 1'b0;
      u_pipe5_core.u_imem.mem[3] = 32'h0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (15) @(posedge clk);
      @(negedge clk);
      check("R1 squashed instruction never writes", dbg_data, old21);
      rst_n = 1'b0;

      // write-back latency of word 3
      u_pipe5_core.u_imem.mem[3] = f_r(F_ADD, 5'd21, 5'd1, 5'd2);
      @(negedge clk) rst_n = 1'b1;
      repeat (6) @(posedge clk);
      @(negedge clk);
      check("R8 not yet visible after edge 6", dbg_data, old21);
      @(posedge clk);
      @(negedge clk);
      check("R8 visible after edge 7", dbg_data, new21);
      repeat (8) @(posedge clk);
      @(negedge clk);
      check("R8 value held", dbg_data, new21);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      done = 1'b1;
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL R11 watchdog: actual hung expected finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule